// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block sits behind a channel command buffer fetcher and classifies every 32-bit word of the command stream. A word is either an opcode header or a data word that belongs to the most recent header. For each header the parser decodes the opcode in the top nibble and its fields. It reports the operation, a register offset, an opcode-specific argument and the number of data words that follow. It then passes that many words through as data words, each tagged with the register offset it targets. Only after the last of them does it look for the next header.

The number of data words after a header is encoded differently for each opcode. It can be the population count of a mask, a count field in the header, a fixed single address word, or a value left behind by an earlier payload-setting command. That last case is what the wide-count opcodes use. The parser keeps that payload value in a register that starts out marked invalid. A wide-count opcode seen while the payload is invalid raises an error and consumes nothing. Unknown opcodes and unknown extended sub-operations also raise the error flag. They do not disturb the stream, and the next word is decoded as a header. Input ready is always high. Decoded results appear on registered outputs one clock after the word is accepted.

Top module: `cmdstream_parser`

## Requirements
- R1: After reset the header strobe, data strobe and error flag are low, input ready is high, and the payload register holds the invalid marker (all ones). A wide-count opcode sent first therefore reports an error.
- R2: Each word accepted (in_valid high) produces, on the next clock, exactly one strobe: a header strobe or a data strobe. The opcode is reported from bits 31:28. A cycle with in_valid low produces no strobe and does not advance the parser.
- R3: Opcode 0x0 (set class) reports the class ID from bits 15:6 as the argument and the offset from bits 27:16. Its count is the popcount of the mask in bits 5:0. Its data words target offset plus each set mask bit index, in ascending bit order.
- R4: Opcodes 0x1 (incrementing) and 0x2 (non-incrementing) take the offset from bits 27:16 and the count from bits 15:0, and report that count as the argument. Opcode 0x1 data words target offset, offset+1, and so on. Opcode 0x2 data words all target the offset.
- R5: Opcode 0x3 (masked) takes the offset from bits 27:16 and the mask from bits 15:0, which is also its argument. Exactly popcount(mask) data words follow, targeting offset plus each set bit index in ascending order.
- R6: The following opcodes have no data words and an offset of 0, except where an offset is given. Opcode 0x4 reports the offset from bits 27:16 and the immediate bits 15:0 as the argument. Opcode 0x5 reports the word shifted left by 4. Opcode 0x8 reports bits 7:0. Opcodes 0x7 and 0xD report bits 27:0.
- R7: Opcode 0x6 reports offset bits 27:16 and argument bits 15:0 (insert flag 15, type 14, count 13:0). Opcode 0xC reports offset 0 and argument bits 13:0. Each is followed by exactly one address word, which targets the header offset.
- R8: Opcode 0x9 loads bits 15:0, zero-extended, into the payload register. It reports those bits as the argument and has no data words.
- R9: Opcodes 0xA (incrementing) and 0xB (non-incrementing) take the offset from bits 21:0 and their count from the payload register, which they report as the argument. With an invalid payload they raise the error flag, report count 0 and consume no data words. With a payload of 0 they consume none and raise no error.
- R10: Opcode 0xE reports bits 27:0 as its argument. Sub-operation bits 27:24 equal to 0 (acquire lock) or 1 (release lock) raise no error. Any other sub-operation raises the error flag. No data words follow.
- R11: Opcode 0xF raises the error flag for one cycle, alongside its header strobe, with count 0 and argument 0. The next word is decoded as a header.
- R12: While data words are owed, every word is passed as data even if its top nibble looks like an opcode. A header with count 0 returns the parser to header decoding at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word valid |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Always high: one word per cycle |
| hdr_valid | output | 1 | Decoded header strobe |
| hdr_op | output | 4 | Opcode of the header |
| hdr_offset | output | 22 | Register offset of the header |
| hdr_arg | output | 32 | Opcode-specific argument |
| hdr_count | output | 16 | Data words that follow the header |
| data_valid | output | 1 | Data word strobe |
| data_word | output | 32 | Data word passed through |
| data_offset | output | 22 | Register offset the data word targets |
| err | output | 1 | Error pulse for a bad header |

## Verification
The bench sweeps every set-class mask and a spread of masked-write masks. It walks the expected target offsets bit by bit, so a walk that skipped a bit, visited bits out of order, or stopped one word early or late would mislabel or swallow the following header. Data words are chosen to look like invalid-opcode headers, so a parser that leaves data mode too soon would raise a spurious error. The wide-count opcodes are driven before any payload load and with payloads of 0, 3 and 256, which catches a design that treats the reset marker as a large count or hangs on a zero count. Idle gaps inside a data run check that an idle cycle does not count as a consumed word.

// File: rtl/cmdp_pkg.sv
// Shared opcode encodings and helpers for the command stream parser.
// Assumes the opcode sits in the top nibble of a 32-bit command word.
package cmdp_pkg;

    typedef enum logic [3:0] {
        OP_CLASS   = 4'h0,
        OP_SEQ     = 4'h1,
        OP_SAME    = 4'h2,
        OP_SEL     = 4'h3,
        OP_INLINE  = 4'h4,
        OP_JUMP    = 4'h5,
        OP_FETCH   = 4'h6,
        OP_STREAM  = 4'h7,
        OP_APP     = 4'h8,
        OP_LOADCNT = 4'h9,
        OP_SEQ_W   = 4'hA,
        OP_SAME_W  = 4'hB,
        OP_FETCH_W = 4'hC,
        OP_JUMP_W  = 4'hD,
        OP_EXT     = 4'hE,
        OP_BAD     = 4'hF
    } op_e;

    // How successive data words derive their target offset.
    typedef enum logic [1:0] {
        WALK_STEP = 2'd0,   // offset, offset+1, ...
        WALK_HOLD = 2'd1,   // always the header offset
        WALK_BITS = 2'd2    // offset plus index of each set mask bit
    } walk_e;

    localparam int MASK_W = 16;

    // Population count of a mask word.
    function automatic logic [4:0] popcnt16(input logic [MASK_W-1:0] v);
        logic [4:0] n;
        n = '0;
        for (int i = 0; i < MASK_W; i++) n = n + 5'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/cmdp_lowbit.sv
// Finds the index of the lowest set bit of a vector.
// Assumes W is a power of two; 'any' is low when the vector is zero.
module cmdp_lowbit #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmdp_payload.sv
// Holds the count left by the payload-setting opcode.
// Assumes loads carry 16 bits; the all-ones reset value marks it invalid.
module cmdp_payload #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [15:0]      din,
    output logic [CNT_W-1:0] cnt,
    output logic             ok
);
    logic [31:0] pay_q;

    // Load on a payload header; reset to the invalid marker.
    always_ff @(posedge clk) begin
        if (!rst_n)    pay_q <= '1;
        else if (load) pay_q <= {16'h0, din};
    end

    assign ok  = (pay_q != '1);
    assign cnt = CNT_W'(pay_q[15:0]);
endmodule

// File: rtl/cmdp_hdr_decode.sv
// Combinational decode of one header word into fields and a data-word count.
// Assumes the payload inputs reflect all payload loads before this word.
module cmdp_hdr_decode
    import cmdp_pkg::*;
#(
    parameter int OFF_W = 22,
    parameter int CNT_W = 16
) (
    input  logic [31:0]       word,
    input  logic              pay_ok,
    input  logic [CNT_W-1:0]  pay_cnt,
    output op_e               op,
    output logic [OFF_W-1:0]  off,
    output logic [31:0]       arg,
    output logic [CNT_W-1:0]  cnt,
    output walk_e             walk,
    output logic [MASK_W-1:0] mask,
    output logic              bad
);
    logic [OFF_W-1:0] off12;
    logic [OFF_W-1:0] off22;

    assign op    = op_e'(word[31:28]);
    assign off12 = OFF_W'(word[27:16]);
    assign off22 = OFF_W'(word[21:0]);

    // Per-opcode field extraction and data-word count.
    always_comb begin
        off  = '0;
        arg  = {4'h0, word[27:0]};
        cnt  = '0;
        walk = WALK_HOLD;
        mask = '0;
        bad  = 1'b0;
        unique case (op)
            OP_CLASS: begin
                off  = off12;
                arg  = 32'(word[15:6]);
                mask = MASK_W'(word[5:0]);
                cnt  = CNT_W'(popcnt16(MASK_W'(word[5:0])));
                walk = WALK_BITS;
            end
            OP_SEQ, OP_SAME: begin
                off  = off12;
                arg  = 32'(word[15:0]);
                cnt  = CNT_W'(word[15:0]);
                walk = (op == OP_SEQ) ? WALK_STEP : WALK_HOLD;
            end
            OP_SEL: begin
                off  = off12;
                arg  = 32'(word[15:0]);
                mask = word[15:0];
                cnt  = CNT_W'(popcnt16(word[15:0]));
                walk = WALK_BITS;
            end
            OP_INLINE: begin
                off = off12;
                arg = 32'(word[15:0]);
            end
            OP_JUMP:    arg = word << 4;
            OP_FETCH: begin
                off = off12;
                arg = 32'(word[15:0]);
                cnt = CNT_W'(1);
            end
            OP_APP:     arg = 32'(word[7:0]);
            OP_LOADCNT: arg = 32'(word[15:0]);
            OP_SEQ_W, OP_SAME_W: begin
                off  = off22;
                walk = (op == OP_SEQ_W) ? WALK_STEP : WALK_HOLD;
                if (pay_ok) begin
                    cnt = pay_cnt;
                    arg = 32'(pay_cnt);
                end else begin
                    arg = '0;
                    bad = 1'b1;
                end
            end
            OP_FETCH_W: begin
                arg = 32'(word[13:0]);
                cnt = CNT_W'(1);
            end
            OP_EXT:     bad = (word[27:24] > 4'd1);
            OP_BAD: begin
                arg = '0;
                bad = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cmdstream_parser.sv
// Command stream parser: splits a word stream into headers and data words.
// Assumes one word per cycle at most; ready is always high; outputs are
// registered and appear one clock after the word is accepted.
module cmdstream_parser
    import cmdp_pkg::*;
#(
    parameter int OFF_W = 22,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_word,
    output logic             in_ready,
    output logic             hdr_valid,
    output logic [3:0]       hdr_op,
    output logic [OFF_W-1:0] hdr_offset,
    output logic [31:0]      hdr_arg,
    output logic [CNT_W-1:0] hdr_count,
    output logic             data_valid,
    output logic [31:0]      data_word,
    output logic [OFF_W-1:0] data_offset,
    output logic             err
);
    // Decode results
    op_e               d_op;
    logic [OFF_W-1:0]  d_off;
    logic [31:0]       d_arg;
    logic [CNT_W-1:0]  d_cnt;
    walk_e             d_walk;
    logic [MASK_W-1:0] d_mask;
    logic              d_bad;

    // Payload register
    logic              pay_ok;
    logic [CNT_W-1:0]  pay_cnt;
    logic              pay_load;

    // Data-run state
    logic              in_data;
    logic [CNT_W-1:0]  rem_q;
    logic [OFF_W-1:0]  cur_off;
    walk_e             walk_q;
    logic [MASK_W-1:0] mask_q;
    logic [IDX_W-1:0]  low_idx;
    logic              low_any;

    assign in_ready = 1'b1;
    assign pay_load = in_valid && !in_data && (in_word[31:28] == OP_LOADCNT);

    cmdp_payload #(.CNT_W(CNT_W)) u_pay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pay_load),
        .din   (in_word[15:0]),
        .cnt   (pay_cnt),
        .ok    (pay_ok)
    );

    cmdp_hdr_decode #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_dec (
        .word    (in_word),
        .pay_ok  (pay_ok),
        .pay_cnt (pay_cnt),
        .op      (d_op),
        .off     (d_off),
        .arg     (d_arg),
        .cnt     (d_cnt),
        .walk    (d_walk),
        .mask    (d_mask),
        .bad     (d_bad)
    );

    cmdp_lowbit #(.W(MASK_W)) u_low (
        .vec (mask_q),
        .idx (low_idx),
        .any (low_any)
    );

    // Header/data sequencing and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_data     <= 1'b0;
            rem_q       <= '0;
            cur_off     <= '0;
            walk_q      <= WALK_HOLD;
            mask_q      <= '0;
            hdr_valid   <= 1'b0;
            hdr_op      <= '0;
            hdr_offset  <= '0;
            hdr_arg     <= '0;
            hdr_count   <= '0;
            data_valid  <= 1'b0;
            data_word   <= '0;
            data_offset <= '0;
            err         <= 1'b0;
        end else begin
            hdr_valid  <= 1'b0;
            data_valid <= 1'b0;
            err        <= 1'b0;
            if (in_valid) begin
                if (in_data) begin
                    data_valid <= 1'b1;
                    data_word  <= in_word;
                    unique case (walk_q)
                        WALK_STEP: begin
                            data_offset <= cur_off;
                            cur_off     <= cur_off + OFF_W'(1);
                        end
                        WALK_BITS: begin
                            data_offset <= cur_off + OFF_W'(low_idx);
                            mask_q      <= mask_q & (mask_q - MASK_W'(1));
                        end
                        default: data_offset <= cur_off;
                    endcase
                    rem_q <= rem_q - CNT_W'(1);
                    if (rem_q == CNT_W'(1)) in_data <= 1'b0;
                end else begin
                    hdr_valid  <= 1'b1;
                    hdr_op     <= d_op;
                    hdr_offset <= d_off;
                    hdr_arg    <= d_arg;
                    hdr_count  <= d_cnt;
                    err        <= d_bad;
                    if (d_cnt != '0) begin
                        in_data <= 1'b1;
                        rem_q   <= d_cnt;
                        cur_off <= d_off;
                        walk_q  <= d_walk;
                        mask_q  <= d_mask;
                    end
                end
            end
        end
    end

    // R2: one strobe kind per accepted word.
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_valid && data_valid));

    // R2: an idle input cycle yields no strobe next cycle.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(hdr_valid || data_valid));

    // R12: a data run never holds a zero remaining count.
    a_r12_rem_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |-> (rem_q != '0));

    // R5: the mask still holds one set bit per owed word.
    a_r5_mask_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && walk_q == WALK_BITS) |-> (low_any && (CNT_W'($countones(mask_q)) == rem_q)));

    // R8: a payload header loads its low half.
    a_r8_payload_load: assert property (@(posedge clk) disable iff (!rst_n)
        pay_load |=> (pay_ok && pay_cnt == CNT_W'($past(in_word[15:0]))));

    // R9: a wide-count error consumes no data words.
    a_r9_wide_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && err && (hdr_op == OP_SEQ_W || hdr_op == OP_SAME_W))
            |-> (hdr_count == '0 && !in_data));

    // R11: the error flag only accompanies a header strobe.
    a_r11_err_with_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> hdr_valid);
endmodule

// File: tb/tb_cmdstream_parser.sv
module tb_cmdstream_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        hdr_valid;
    logic [3:0]  hdr_op;
    logic [21:0] hdr_offset;
    logic [31:0] hdr_arg;
    logic [15:0] hdr_count;
    logic        data_valid;
    logic [31:0] data_word;
    logic [21:0] data_offset;
    logic        err;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cmdstream_parser dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .hdr_valid(hdr_valid), .hdr_op(hdr_op),
        .hdr_offset(hdr_offset), .hdr_arg(hdr_arg), .hdr_count(hdr_count),
        .data_valid(data_valid), .data_word(data_word),
        .data_offset(data_offset), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Drive one word at a falling edge; return at the next falling edge.
    task automatic send(input logic [31:0] w);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle_chk(input string tag);
        @(negedge clk);
        chk(!hdr_valid && !data_valid && !err, tag,
            {hdr_valid, data_valid, err}, 3'b000);
    endtask

    task automatic hdr_chk(input logic [31:0] w, input logic [21:0] off,
                           input logic [31:0] arg, input logic [15:0] cnt,
                           input bit e, input string tag);
        logic [127:0] a, x;
        send(w);
        a = {hdr_valid, data_valid, hdr_op, hdr_offset, hdr_arg, hdr_count, err};
        x = {1'b1, 1'b0, w[31:28], off, arg, cnt, e};
        chk(a == x, tag, a, x);
    endtask

    task automatic dat_chk(input logic [31:0] w, input logic [21:0] off,
                           input string tag);
        logic [127:0] a, x;
        send(w);
        a = {data_valid, hdr_valid, err, data_word, data_offset};
        x = {1'b1, 1'b0, 1'b0, w, off};
        chk(a == x, tag, a, x);
    endtask

    function automatic logic [15:0] pc(input logic [15:0] v);
        logic [15:0] n = '0;
        for (int i = 0; i < 16; i++) n = n + 16'(v[i]);
        return n;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(!hdr_valid && !data_valid && !err && in_ready, "R1 reset outputs",
            {hdr_valid, data_valid, err, in_ready}, 4'b0001);
        // R1 R9: invalid payload after reset
        hdr_chk(32'hA000_0005, 22'h5, 32'h0, 16'h0, 1'b1, "R1 R9 wide before load");
        idle_chk("R11 error is one cycle");
        hdr_chk(32'hB012_3456, 22'h12_3456, 32'h0, 16'h0, 1'b1, "R9 nonincr_w invalid");
        hdr_chk(32'h4ABC_1234, 22'hABC, 32'h1234, 16'h0, 1'b0, "R9 next is header");

        // R3: every set-class mask
        for (int m = 0; m < 64; m++) begin
            logic [11:0] off;
            logic [9:0]  cls;
            off = 12'((m * 37 + 1) & 12'hfff);
            cls = 10'(m * 13);
            hdr_chk({4'h0, off, cls, 6'(m)}, 22'(off), 32'(cls), pc(16'(m)), 1'b0,
                    "R3 set class header");
            for (int b = 0; b < 6; b++)
                if (m[b]) dat_chk(32'hF000_0000 | 32'(m << 8) | 32'(b),
                                  22'(off) + 22'(b), "R3 R12 class data");
        end

        // R4: incrementing and non-incrementing runs
        for (int n = 0; n < 6; n++) begin
            hdr_chk({4'h1, 12'hFFC, 16'(n)}, 22'hFFC, 32'(n), 16'(n), 1'b0, "R4 incr header");
            for (int k = 0; k < n; k++)
                dat_chk(32'h9000_0000 + 32'(k), 22'hFFC + 22'(k), "R4 incr data");
            hdr_chk({4'h2, 12'h010, 16'(n)}, 22'h010, 32'(n), 16'(n), 1'b0, "R4 nonincr header");
            for (int k = 0; k < n; k++)
                dat_chk(32'hE500_0000 + 32'(k), 22'h010, "R4 nonincr data");
        end

        // R5: masked writes over a spread of masks
        for (int i = 0; i < 67; i++) begin
            logic [15:0] m;
            m = (i == 64) ? 16'h0000 : (i == 65) ? 16'hFFFF : (i == 66) ? 16'h8000
                : 16'((i * 16'h9E37) ^ (i << 3));
            hdr_chk({4'h3, 12'h200, m}, 22'h200, 32'(m), pc(m), 1'b0, "R5 mask header");
            for (int b = 0; b < 16; b++)
                if (m[b]) dat_chk(32'hF0F0_0000 | 32'(b), 22'h200 + 22'(b), "R5 mask data");
        end

        // R6: no-data opcodes
        hdr_chk(32'h4FFF_FFFF, 22'hFFF, 32'h0000_FFFF, 16'h0, 1'b0, "R6 immediate");
        hdr_chk(32'h5123_4567, 22'h0, 32'h1234_5670, 16'h0, 1'b0, "R6 restart");
        hdr_chk(32'h8765_43A5, 22'h0, 32'h0000_00A5, 16'h0, 1'b0, "R6 app id");
        hdr_chk(32'h7ABC_DEF1, 22'h0, 32'h0ABC_DEF1, 16'h0, 1'b0, "R6 stream id");
        hdr_chk(32'hD123_4567, 22'h0, 32'h0123_4567, 16'h0, 1'b0, "R6 restart wide");

        // R7: gather headers with one address word
        hdr_chk(32'h6345_C123, 22'h345, 32'h0000_C123, 16'h1, 1'b0, "R7 gather header");
        dat_chk(32'h6000_0000, 22'h345, "R7 R12 gather address");
        hdr_chk(32'hC000_FFFF, 22'h0, 32'h0000_3FFF, 16'h1, 1'b0, "R7 gather wide header");
        dat_chk(32'hDEAD_BEEF, 22'h0, "R7 gather wide address");

        // R8 R9: payload-driven wide runs
        hdr_chk(32'h9FFF_0003, 22'h0, 32'h3, 16'h0, 1'b0, "R8 payload load");
        hdr_chk(32'hA03F_FFF0, 22'h3F_FFF0, 32'h3, 16'h3, 1'b0, "R9 incr_w header");
        for (int k = 0; k < 3; k++)
            dat_chk(32'hA000_0000 + 32'(k), 22'h3F_FFF0 + 22'(k), "R9 incr_w data");
        hdr_chk(32'hB000_0042, 22'h42, 32'h3, 16'h3, 1'b0, "R9 nonincr_w header");
        for (int k = 0; k < 3; k++)
            dat_chk(32'hB000_0000 + 32'(k), 22'h42, "R9 nonincr_w data");
        hdr_chk(32'h9000_0000, 22'h0, 32'h0, 16'h0, 1'b0, "R8 payload zero");
        hdr_chk(32'hA000_0001, 22'h1, 32'h0, 16'h0, 1'b0, "R9 zero count");
        hdr_chk(32'h9000_0100, 22'h0, 32'h100, 16'h0, 1'b0, "R8 payload 256");
        hdr_chk(32'hA000_0000, 22'h0, 32'h100, 16'h100, 1'b0, "R9 long run header");
        for (int k = 0; k < 256; k++)
            dat_chk(32'hF000_0000 + 32'(k), 22'(k), "R9 long run data");

        // R10: extend sub-operations
        for (int s = 0; s < 16; s++)
            hdr_chk({4'hE, 4'(s), 24'h00_0007}, 22'h0, {4'h0, 4'(s), 24'h00_0007},
                    16'h0, (s > 1), "R10 extend sub-op");

        // R11: invalid opcode, then recovery
        hdr_chk(32'hF123_4567, 22'h0, 32'h0, 16'h0, 1'b1, "R11 bad opcode");
        idle_chk("R11 error clears");
        hdr_chk(32'h4001_0002, 22'h001, 32'h2, 16'h0, 1'b0, "R11 resumes header");

        // R2 R12: idle gaps inside a run do not consume words
        hdr_chk({4'h1, 12'h100, 16'h3}, 22'h100, 32'h3, 16'h3, 1'b0, "R12 gap header");
        dat_chk(32'h1111_1111, 22'h100, "R12 gap data");
        idle_chk("R2 idle in run");
        idle_chk("R2 idle in run");
        dat_chk(32'h2222_2222, 22'h101, "R12 gap data");
        dat_chk(32'h3333_3333, 22'h102, "R12 gap data");
        hdr_chk(32'h0000_0000, 22'h0, 32'h0, 16'h0, 1'b0, "R12 zero count header");
        hdr_chk(32'h4000_0001, 22'h0, 32'h1, 16'h0, 1'b0, "R12 header after zero");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule